// File: doc/BRIEF.md
# Disk Command Protocol Monitor and Error Encoder

This block sits beside a rigid-disk controller and watches the command traffic between the host processor and the controller. It checks that each request to run an operation was preceded by a request to fetch the command block. It checks that the opcode and diagnostic mode are legal, and that the drive is ready and the head position is known before a transfer starts. While an operation runs, it counts index pulses so it can tell when the FIFO stays full during a read or empty during a write for too many disk revolutions.

Each problem is reduced to a single byte with two nibbles. The upper nibble selects the error class: 0 for FIFO handshake faults, 1, 2 and 3 for header, label and data faults, and 8 for faults that are not split into nibbles. Only the first error of an operation is kept. The block also tracks the current head cylinder, holding an all-ones "unknown" marker while a seek is in flight. It counts sectors with a two's-complement count, and it presents drive and controller status bytes through a synchronizer.

Top module: `disk_cmd_monitor`

## Requirements
- R1: An execute strobe with an opcode outside {0..7, 10} reports 8'h8A. An execute strobe with opcode 10 and a diagnostic mode not below DIAG_MODES (default 2) reports 8'h8B. A rejected execute starts no operation.
- R2: An execute strobe that has not been preceded by a get strobe since the previous execute reports 8'h8C, and no operation starts.
- R3: An execute strobe with a transfer opcode (anything legal except 0) reports 8'h8D when drive ready or seek complete is low. Otherwise it reports 8'h84 when the current cylinder is 16'hFFFF. Opcode 0 skips both checks.
- R4: A get strobe while the FIFO is empty reports 8'h01. A load strobe while the FIFO is not empty reports 8'h07. An execute of a read-class opcode (2, 5, 6, 7, 10) while the FIFO is not empty reports 8'h03.
- R5: During a read-class operation, FULL_REVS (default 4) index rising edges with the FIFO full report 8'h04. During a write-class operation (1, 3, 4), EMPTY_REVS (default 3) index rising edges with the FIFO empty report 8'h05. The count restarts whenever the condition clears.
- R6: While an operation runs, a sector-miss strobe reports 8'h81, and a write fault during a write-class operation reports 8'h85. A data-path fault with field f in 1..3 and kind k in 1..5 reports {f,k} as two nibbles. Any other field or kind value is ignored.
- R7: err_valid and err_code are registered on the clock edge of the event. The first error is held unchanged until the next get strobe, which clears it to 8'h00 (unless that get itself errs).
- R8: A seek-begin strobe sets cur_cyl to 16'hFFFF. A seek-end strobe loads seek_cyl when it is below NUM_CYLS (default 1024). Otherwise it leaves 16'hFFFF and reports 8'h82.
- R9: drv_status bit order from bit7 to bit0 is {not ready, not seek complete, 0, address mark, not index, not track 0, not write fault, lock}, delayed by SYNC_STAGES (default 2) clocks.
- R10: ctl_status bit0 is FIFO full, bit1 is FIFO empty, bit5 is FIFO empty during a read-class operation, and the other bits are 0. The byte is delayed by SYNC_STAGES clocks.
- R11: An accepted execute loads sec_count (two's complement) and raises op_busy. Each sector tick increments the count, and op_busy falls on the tick that brings it to zero.
- R12: After reset err_valid is 0, err_code is 8'h00, op_busy is 0 and cur_cyl is 16'hFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| get_cb | input | 1 | Fetch-command-block strobe |
| exec_cb | input | 1 | Run-command-block strobe |
| load_cb | input | 1 | Return-status-block strobe |
| opcode | input | 4 | Operation code sampled with exec_cb |
| diag_mode | input | 2 | Diagnostic sub-mode sampled with exec_cb |
| sec_count | input | 16 | Two's-complement sector count sampled with exec_cb |
| sector_tick | input | 1 | One sector finished |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_full | input | 1 | FIFO full flag |
| drv_index | input | 1 | Drive index pulse |
| drv_ready | input | 1 | Drive ready |
| drv_seek_done | input | 1 | Drive seek complete |
| drv_wfault | input | 1 | Drive write fault |
| drv_lock | input | 1 | Drive lock detected |
| drv_track0 | input | 1 | Head at track 0 |
| drv_am | input | 1 | Address mark detected |
| seek_begin | input | 1 | Seek started |
| seek_end | input | 1 | Seek finished |
| seek_cyl | input | 16 | Target cylinder, valid with seek_end |
| sec_miss | input | 1 | Sector not found |
| dp_fault | input | 1 | Data-path fault strobe |
| dp_field | input | 2 | Fault field: 1 header, 2 label, 3 data |
| dp_kind | input | 3 | Fault kind: 1 mark, 2 ID, 3 compare, 4 CRC, 5 both |
| err_code | output | 8 | Latched error byte |
| err_valid | output | 1 | An error is latched |
| drv_status | output | 8 | Synchronized drive status |
| ctl_status | output | 8 | Synchronized controller status |
| cur_cyl | output | 16 | Current cylinder, 16'hFFFF when unknown |
| op_busy | output | 1 | Operation in progress |

## Verification
A table walks the execute check through legal, illegal and diagnostic opcodes. Each is paired with a missing get, a FIFO that is or is not empty, and a drive that is not ready or whose seek is not done. Because the failures are layered, each row shows which check outranks the others. Directed runs feed runs of index pulses that stop one short of the limit, are broken by a cleared FIFO condition, and then reach it. These runs separate "restart on clear" from "count while armed". Data-path faults with legal and unused field or kind values show that only encodable codes appear. A second error arriving while one is held shows that the first is the one kept.

// File: rtl/dcm_pkg.sv
package dcm_pkg;
   localparam logic [7:0] ERR_NONE           = 8'h00;
   localparam logic [7:0] ERR_GET_EMPTY      = 8'h01;
   localparam logic [7:0] ERR_RD_NOT_EMPTY   = 8'h03;
   localparam logic [7:0] ERR_RD_STUCK_FULL  = 8'h04;
   localparam logic [7:0] ERR_WR_STUCK_EMPTY = 8'h05;
   localparam logic [7:0] ERR_LOAD_NOT_EMPTY = 8'h07;
   localparam logic [7:0] ERR_NO_SECTOR      = 8'h81;
   localparam logic [7:0] ERR_CYL_OVERFLOW   = 8'h82;
   localparam logic [7:0] ERR_CYL_UNKNOWN    = 8'h84;
   localparam logic [7:0] ERR_WRITE_FAULT    = 8'h85;
   localparam logic [7:0] ERR_BAD_OPCODE     = 8'h8A;
   localparam logic [7:0] ERR_BAD_DIAG       = 8'h8B;
   localparam logic [7:0] ERR_SEQUENCE       = 8'h8C;
   localparam logic [7:0] ERR_DRIVE_IDLE     = 8'h8D;

   typedef struct packed {
      logic       hit;
      logic [7:0] code;
   } err_cand_t;

   // class nibble in the upper half, kind in the lower half
   function automatic logic [7:0] field_code(input logic [1:0] field, input logic [2:0] kind);
      return {2'b00, field, 1'b0, kind};
   endfunction

   function automatic logic field_ok(input logic [1:0] field, input logic [2:0] kind);
      return (field != 2'd0) && (kind >= 3'd1) && (kind <= 3'd5);
   endfunction
endpackage

// File: rtl/dcm_rev_watch.sv
module dcm_rev_watch #(
   parameter int LIMIT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic idx_rise,
   output logic expire
);
   localparam int CW = $clog2(LIMIT + 1);

   if (LIMIT < 1) begin : g_bad_limit
      $error("dcm_rev_watch: LIMIT must be at least 1");
   end

   logic [CW-1:0] revs;

   assign expire = arm && idx_rise && (revs == CW'(LIMIT - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         revs <= '0;
      else if (!arm)
         revs <= '0;
      else if (idx_rise)
         revs <= expire ? '0 : revs + 1'b1;
   end
endmodule

// File: rtl/dcm_sync_byte.sv
module dcm_sync_byte #(
   parameter int         STAGES  = 2,
   parameter logic [7:0] RST_VAL = 8'h00
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [7:0] d,
   output logic [7:0] q
);
   if (STAGES < 0) begin : g_bad_stages
      $error("dcm_sync_byte: STAGES must not be negative");
   end

   if (STAGES == 0) begin : g_bypass
      assign q = d;
   end else begin : g_chain
      logic [7:0] pipe [STAGES];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
         end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
         end
      end
      assign q = pipe[STAGES-1];
   end
endmodule

// File: rtl/dcm_cyl_track.sv
module dcm_cyl_track #(
   parameter int CYL_W    = 16,
   parameter int NUM_CYLS = 1024
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             seek_begin,
   input  logic             seek_end,
   input  logic [CYL_W-1:0] seek_cyl,
   output logic [CYL_W-1:0] cur_cyl,
   output logic             known,
   output logic             overflow
);
   localparam logic [CYL_W-1:0] UNKNOWN = '1;
   localparam logic [CYL_W-1:0] LIMIT   = CYL_W'(NUM_CYLS);

   if (NUM_CYLS < 1 || NUM_CYLS > (2**CYL_W) - 1) begin : g_bad_cyls
      $error("dcm_cyl_track: NUM_CYLS must leave the all-ones code unused");
   end

   assign overflow = seek_end && (seek_cyl >= LIMIT);
   assign known    = (cur_cyl != UNKNOWN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cur_cyl <= UNKNOWN;
      else if (seek_end)
         cur_cyl <= overflow ? UNKNOWN : seek_cyl;
      else if (seek_begin)
         cur_cyl <= UNKNOWN;
   end
endmodule

// File: rtl/disk_cmd_monitor.sv
module disk_cmd_monitor #(
   parameter int OP_W        = 4,
   parameter int MODE_W      = 2,
   parameter int DIAG_OP     = 10,
   parameter int DIAG_MODES  = 2,
   parameter int CNT_W       = 16,
   parameter int CYL_W       = 16,
   parameter int NUM_CYLS    = 1024,
   parameter int FULL_REVS   = 4,
   parameter int EMPTY_REVS  = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              get_cb,
   input  logic              exec_cb,
   input  logic              load_cb,
   input  logic [OP_W-1:0]   opcode,
   input  logic [MODE_W-1:0] diag_mode,
   input  logic [CNT_W-1:0]  sec_count,
   input  logic              sector_tick,
   input  logic              fifo_empty,
   input  logic              fifo_full,
   input  logic              drv_index,
   input  logic              drv_ready,
   input  logic              drv_seek_done,
   input  logic              drv_wfault,
   input  logic              drv_lock,
   input  logic              drv_track0,
   input  logic              drv_am,
   input  logic              seek_begin,
   input  logic              seek_end,
   input  logic [CYL_W-1:0]  seek_cyl,
   input  logic              sec_miss,
   input  logic              dp_fault,
   input  logic [1:0]        dp_field,
   input  logic [2:0]        dp_kind,
   output logic [7:0]        err_code,
   output logic              err_valid,
   output logic [7:0]        drv_status,
   output logic [7:0]        ctl_status,
   output logic [CYL_W-1:0]  cur_cyl,
   output logic              op_busy
);
   import dcm_pkg::*;

   localparam logic [OP_W-1:0]   OP_DIAG   = OP_W'(DIAG_OP);
   localparam logic [OP_W-1:0]   OP_STDMAX = OP_W'(7);
   localparam logic [MODE_W-1:0] MODE_LIM  = MODE_W'(DIAG_MODES);

   if (DIAG_OP <= 7 || DIAG_OP >= 2**OP_W) begin : g_bad_diag
      $error("disk_cmd_monitor: DIAG_OP must be above 7 and fit in OP_W");
   end
   if (DIAG_MODES < 1 || DIAG_MODES > (2**MODE_W) - 1) begin : g_bad_modes
      $error("disk_cmd_monitor: DIAG_MODES must leave an illegal mode code");
   end

   // ---------------- opcode classification ----------------
   logic op_legal, op_is_diag, op_is_rd, op_is_wr, op_is_xfer;
   always_comb begin
      op_is_diag = (opcode == OP_DIAG);
      op_legal   = (opcode <= OP_STDMAX) || op_is_diag;
      op_is_rd   = op_is_diag;
      op_is_wr   = 1'b0;
      case (opcode)
         OP_W'(2), OP_W'(5), OP_W'(6), OP_W'(7): op_is_rd = 1'b1;
         OP_W'(1), OP_W'(3), OP_W'(4):           op_is_wr = 1'b1;
         default: ;
      endcase
      op_is_xfer = op_legal && (opcode != '0);
   end

   // ---------------- cylinder tracking ----------------
   logic cyl_known, cyl_ovf;
   dcm_cyl_track #(.CYL_W(CYL_W), .NUM_CYLS(NUM_CYLS)) u_cyl (
      .clk(clk), .rst_n(rst_n), .seek_begin(seek_begin), .seek_end(seek_end),
      .seek_cyl(seek_cyl), .cur_cyl(cur_cyl), .known(cyl_known), .overflow(cyl_ovf)
   );

   // ---------------- command sequence and execute checks ----------------
   logic       got_cb;
   err_cand_t  exec_chk;
   logic       exec_start;

   always_comb begin
      exec_chk = '{hit: 1'b0, code: ERR_NONE};
      if (!got_cb)
         exec_chk = '{hit: 1'b1, code: ERR_SEQUENCE};
      else if (!op_legal)
         exec_chk = '{hit: 1'b1, code: ERR_BAD_OPCODE};
      else if (op_is_diag && diag_mode >= MODE_LIM)
         exec_chk = '{hit: 1'b1, code: ERR_BAD_DIAG};
      else if (op_is_xfer && (!drv_ready || !drv_seek_done))
         exec_chk = '{hit: 1'b1, code: ERR_DRIVE_IDLE};
      else if (op_is_xfer && !cyl_known)
         exec_chk = '{hit: 1'b1, code: ERR_CYL_UNKNOWN};
      else if (op_is_rd && !fifo_empty)
         exec_chk = '{hit: 1'b1, code: ERR_RD_NOT_EMPTY};
   end

   assign exec_start = exec_cb && !exec_chk.hit;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         got_cb <= 1'b0;
      else if (exec_cb)
         got_cb <= 1'b0;
      else if (get_cb)
         got_cb <= 1'b1;
   end

   // ---------------- operation and sector count ----------------
   logic             op_rd, op_wr;
   logic [CNT_W-1:0] sec_left;
   logic [CNT_W-1:0] sec_next;

   assign sec_next = sec_left + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_busy  <= 1'b0;
         op_rd    <= 1'b0;
         op_wr    <= 1'b0;
         sec_left <= '0;
      end else if (exec_start) begin
         op_busy  <= 1'b1;
         op_rd    <= op_is_rd;
         op_wr    <= op_is_wr;
         sec_left <= sec_count;
      end else if (op_busy && sector_tick) begin
         sec_left <= sec_next;
         if (sec_next == '0) op_busy <= 1'b0;
      end
   end

   // ---------------- revolution timeouts ----------------
   logic idx_q, idx_rise, full_expire, empty_expire;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) idx_q <= 1'b0;
      else        idx_q <= drv_index;
   end
   assign idx_rise = drv_index && !idx_q;

   dcm_rev_watch #(.LIMIT(FULL_REVS)) u_full_watch (
      .clk(clk), .rst_n(rst_n), .arm(op_busy && op_rd && fifo_full),
      .idx_rise(idx_rise), .expire(full_expire)
   );
   dcm_rev_watch #(.LIMIT(EMPTY_REVS)) u_empty_watch (
      .clk(clk), .rst_n(rst_n), .arm(op_busy && op_wr && fifo_empty),
      .idx_rise(idx_rise), .expire(empty_expire)
   );

   // ---------------- error selection and first-error latch ----------------
   err_cand_t cand;
   always_comb begin
      cand = '{hit: 1'b0, code: ERR_NONE};
      if (get_cb && fifo_empty)
         cand = '{hit: 1'b1, code: ERR_GET_EMPTY};
      else if (load_cb && !fifo_empty)
         cand = '{hit: 1'b1, code: ERR_LOAD_NOT_EMPTY};
      else if (exec_cb && exec_chk.hit)
         cand = exec_chk;
      else if (cyl_ovf)
         cand = '{hit: 1'b1, code: ERR_CYL_OVERFLOW};
      else if (op_busy && op_wr && drv_wfault)
         cand = '{hit: 1'b1, code: ERR_WRITE_FAULT};
      else if (op_busy && sec_miss)
         cand = '{hit: 1'b1, code: ERR_NO_SECTOR};
      else if (op_busy && dp_fault && field_ok(dp_field, dp_kind))
         cand = '{hit: 1'b1, code: field_code(dp_field, dp_kind)};
      else if (full_expire)
         cand = '{hit: 1'b1, code: ERR_RD_STUCK_FULL};
      else if (empty_expire)
         cand = '{hit: 1'b1, code: ERR_WR_STUCK_EMPTY};
   end

   logic held;
   assign held = err_valid && !get_cb;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err_valid <= 1'b0;
         err_code  <= ERR_NONE;
      end else if (!held && cand.hit) begin
         err_valid <= 1'b1;
         err_code  <= cand.code;
      end else if (get_cb) begin
         err_valid <= 1'b0;
         err_code  <= ERR_NONE;
      end
   end

   // ---------------- status bytes ----------------
   logic [7:0] drv_raw, ctl_raw;
   assign drv_raw = {~drv_ready, ~drv_seek_done, 1'b0, drv_am,
                     ~drv_index, ~drv_track0, ~drv_wfault, drv_lock};
   assign ctl_raw = {2'b00, fifo_empty && op_busy && op_rd, 3'b000, fifo_empty, fifo_full};

   dcm_sync_byte #(.STAGES(SYNC_STAGES), .RST_VAL(8'h00)) u_drv_sync (
      .clk(clk), .rst_n(rst_n), .d(drv_raw), .q(drv_status)
   );
   dcm_sync_byte #(.STAGES(SYNC_STAGES), .RST_VAL(8'h00)) u_ctl_sync (
      .clk(clk), .rst_n(rst_n), .d(ctl_raw), .q(ctl_status)
   );
endmodule

// File: rtl/dcm_checker.sv
module dcm_checker #(
   parameter int CYL_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             get_cb,
   input logic             seek_begin,
   input logic             seek_end,
   input logic             sector_tick,
   input logic [7:0]       err_code,
   input logic             err_valid,
   input logic [CYL_W-1:0] cur_cyl,
   input logic             op_busy
);
   // R7
   err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid && !get_cb |=> err_valid && $stable(err_code));

   // R7
   err_idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !err_valid |-> err_code == 8'h00);

   // R6
   err_space_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err_valid |-> (err_code[7:4] <= 4'd3 || err_code[7:4] == 4'd8) && err_code[3:0] != 4'd0);

   // R8
   cyl_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seek_begin && !seek_end |=> cur_cyl == '1);

   // R11
   busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(op_busy) |-> $past(sector_tick));
endmodule

bind disk_cmd_monitor dcm_checker #(.CYL_W(CYL_W)) i_dcm_checker (
   .clk(clk), .rst_n(rst_n), .get_cb(get_cb), .seek_begin(seek_begin),
   .seek_end(seek_end), .sector_tick(sector_tick), .err_code(err_code),
   .err_valid(err_valid), .cur_cyl(cur_cyl), .op_busy(op_busy)
);

// File: tb/test_disk_cmd_monitor.sv
module test_disk_cmd_monitor;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        get_cb = 0, exec_cb = 0, load_cb = 0;
   logic [3:0]  opcode = 0;
   logic [1:0]  diag_mode = 0;
   logic [15:0] sec_count = 16'hFFFF;
   logic        sector_tick = 0, fifo_empty = 0, fifo_full = 0, drv_index = 0;
   logic        drv_ready = 1, drv_seek_done = 1, drv_wfault = 0, drv_lock = 0;
   logic        drv_track0 = 0, drv_am = 0, seek_begin = 0, seek_end = 0;
   logic [15:0] seek_cyl = 0;
   logic        sec_miss = 0, dp_fault = 0;
   logic [1:0]  dp_field = 0;
   logic [2:0]  dp_kind = 0;
   logic [7:0]  err_code, drv_status, ctl_status;
   logic        err_valid, op_busy;
   logic [15:0] cur_cyl;

   int checks = 0;
   int errors = 0;
   logic [18:0] vec;

   always #10 clk = ~clk;

   disk_cmd_monitor i_disk_cmd_monitor (
      .clk(clk), .rst_n(rst_n), .get_cb(get_cb), .exec_cb(exec_cb), .load_cb(load_cb),
      .opcode(opcode), .diag_mode(diag_mode), .sec_count(sec_count),
      .sector_tick(sector_tick), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
      .drv_index(drv_index), .drv_ready(drv_ready), .drv_seek_done(drv_seek_done),
      .drv_wfault(drv_wfault), .drv_lock(drv_lock), .drv_track0(drv_track0),
      .drv_am(drv_am), .seek_begin(seek_begin), .seek_end(seek_end),
      .seek_cyl(seek_cyl), .sec_miss(sec_miss), .dp_fault(dp_fault),
      .dp_field(dp_field), .dp_kind(dp_kind), .err_code(err_code),
      .err_valid(err_valid), .drv_status(drv_status), .ctl_status(ctl_status),
      .cur_cyl(cur_cyl), .op_busy(op_busy)
   );

   // vector: op[18:15] mode[14:13] get[12] fe[11] rdy[10] skc[9] code[8:1] valid[0]
   function automatic logic [18:0] mkv(input logic [3:0] op, input logic [1:0] md,
      input logic g, input logic fe, input logic rdy, input logic skc,
      input logic [7:0] code, input logic vld);
      return {op, md, g, fe, rdy, skc, code, vld};
   endfunction

   localparam int NV = 13;
   localparam logic [18:0] VECS [NV] = '{
      mkv(4'd2,  2'd0, 1, 1, 1, 1, 8'h00, 0),   // R4 read with empty FIFO accepted
      mkv(4'd2,  2'd0, 1, 0, 1, 1, 8'h03, 1),   // R4
      mkv(4'd3,  2'd0, 1, 0, 1, 1, 8'h00, 0),   // R4 write ignores FIFO content
      mkv(4'd0,  2'd0, 1, 0, 0, 1, 8'h00, 0),   // R3 restore skips drive check
      mkv(4'd3,  2'd0, 1, 0, 0, 1, 8'h8D, 1),   // R3
      mkv(4'd5,  2'd0, 1, 1, 1, 0, 8'h8D, 1),   // R3
      mkv(4'd8,  2'd0, 1, 1, 1, 1, 8'h8A, 1),   // R1
      mkv(4'd15, 2'd0, 1, 1, 1, 1, 8'h8A, 1),   // R1
      mkv(4'd10, 2'd1, 1, 1, 1, 1, 8'h00, 0),   // R1 legal diagnostic
      mkv(4'd2,  2'd0, 0, 1, 1, 1, 8'h8C, 1),   // R2
      mkv(4'd10, 2'd3, 1, 1, 1, 1, 8'h8B, 1),   // R1
      mkv(4'd7,  2'd0, 1, 0, 1, 1, 8'h03, 1),   // R4
      mkv(4'd1,  2'd0, 1, 1, 1, 1, 8'h00, 0)    // R4 format accepted
   };

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_get();   get_cb = 1;      cyc(1); get_cb = 0;      endtask
   task automatic do_exec();  exec_cb = 1;     cyc(1); exec_cb = 0;     endtask
   task automatic do_load();  load_cb = 1;     cyc(1); load_cb = 0;     endtask
   task automatic do_tick();  sector_tick = 1; cyc(1); sector_tick = 0; endtask
   task automatic do_index(); drv_index = 1;   cyc(2); drv_index = 0; cyc(2); endtask

   task automatic start_op(input logic [3:0] op, input logic fe_at_exec);
      fifo_empty = 0; do_get();
      fifo_empty = fe_at_exec; opcode = op; diag_mode = 0; do_exec();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      cyc(2);
      // R12 reset state
      chk("R12", "err_valid", err_valid, 0);
      chk("R12", "err_code", err_code, 8'h00);
      chk("R12", "op_busy", op_busy, 0);
      chk("R12", "cur_cyl", cur_cyl, 16'hFFFF);
      rst_n = 1; cyc(4);
      // R9 / R10 defaults
      chk("R9", "drv_status idle", drv_status, 8'h0E);
      chk("R10", "ctl_status idle", ctl_status, 8'h00);
      drv_lock = 1; drv_track0 = 1; drv_am = 1; drv_ready = 0; fifo_full = 1;
      cyc(1);
      chk("R9", "drv_status before sync", drv_status, 8'h0E);
      cyc(2);
      chk("R9", "drv_status pattern", drv_status, 8'h9B);
      chk("R10", "ctl_status full", ctl_status, 8'h01);
      drv_lock = 0; drv_track0 = 0; drv_am = 0; drv_ready = 1; fifo_full = 0;

      // R3 unknown cylinder at execute
      start_op(4'd2, 1);
      chk("R3", "unknown cylinder", err_code, 8'h84);
      chk("R3", "no start on 84", op_busy, 0);
      // R7 held error survives a later violation
      opcode = 4'd9; do_exec();
      chk("R7", "first error held", err_code, 8'h84);
      fifo_empty = 0; do_get();
      chk("R7", "get clears valid", err_valid, 0);
      chk("R7", "get clears code", err_code, 8'h00);

      // R8 cylinder tracking
      seek_cyl = 16'h0123; seek_end = 1; cyc(1); seek_end = 0;
      chk("R8", "seek end loads", cur_cyl, 16'h0123);
      seek_begin = 1; cyc(1); seek_begin = 0;
      chk("R8", "seek begin undefined", cur_cyl, 16'hFFFF);
      seek_cyl = 16'd1024; seek_end = 1; cyc(1); seek_end = 0;
      chk("R8", "overflow keeps undefined", cur_cyl, 16'hFFFF);
      chk("R8", "overflow code", err_code, 8'h82);
      fifo_empty = 0; do_get();
      seek_cyl = 16'd1023; seek_end = 1; cyc(1); seek_end = 0;
      chk("R8", "top cylinder accepted", cur_cyl, 16'd1023);
      chk("R8", "no error on top", err_valid, 0);

      // R4 get and load FIFO checks
      fifo_empty = 1; do_get();
      chk("R4", "get with empty FIFO", err_code, 8'h01);
      fifo_empty = 0; do_get();
      chk("R4", "get with data clears", err_valid, 0);
      do_load();
      chk("R4", "load with data", err_code, 8'h07);
      do_get(); fifo_empty = 1; do_load();
      chk("R4", "load with empty FIFO", err_valid, 0);

      // table walk over execute checks (R1 R2 R3 R4)
      for (int i = 0; i < NV; i++) begin
         vec = VECS[i];
         fifo_empty = 0;
         if (vec[12]) do_get();
         opcode = vec[18:15]; diag_mode = vec[14:13];
         fifo_empty = vec[11]; drv_ready = vec[10]; drv_seek_done = vec[9];
         do_exec();
         chk($sformatf("R1-table[%0d]", i), "err_valid", err_valid, vec[0]);
         chk($sformatf("R2-table[%0d]", i), "err_code", err_code, vec[8:1]);
         chk($sformatf("R11-table[%0d]", i), "op_busy", op_busy, !vec[0]);
         do_tick();
         drv_ready = 1; drv_seek_done = 1;
      end
      chk("R11", "idle after table", op_busy, 0);

      // R5 read stuck full with restart
      start_op(4'd2, 1);
      chk("R5", "read started", op_busy, 1);
      fifo_empty = 0; fifo_full = 1;
      for (int k = 0; k < 3; k++) do_index();
      chk("R5", "three full revs", err_valid, 0);
      fifo_full = 0; cyc(1); fifo_full = 1;
      for (int k = 0; k < 3; k++) do_index();
      chk("R5", "restart after clear", err_valid, 0);
      do_index();
      chk("R5", "four full revs", err_code, 8'h04);
      fifo_full = 0; do_tick();

      // R5 write stuck empty
      start_op(4'd3, 0);
      fifo_empty = 1;
      for (int k = 0; k < 2; k++) do_index();
      chk("R5", "two empty revs", err_valid, 0);
      do_index();
      chk("R5", "three empty revs", err_code, 8'h05);
      do_tick();

      // R6 write fault
      start_op(4'd4, 0);
      drv_wfault = 1; cyc(1); drv_wfault = 0;
      chk("R6", "write fault", err_code, 8'h85);
      do_tick();

      // R10 / R6 data path faults during a read
      start_op(4'd6, 1);
      cyc(3);
      chk("R10", "empty at read", ctl_status, 8'h22);
      dp_field = 0; dp_kind = 1; dp_fault = 1; cyc(1); dp_fault = 0;
      chk("R6", "field 0 ignored", err_valid, 0);
      dp_field = 1; dp_kind = 6; dp_fault = 1; cyc(1); dp_fault = 0;
      chk("R6", "kind 6 ignored", err_valid, 0);
      dp_field = 2; dp_kind = 3; dp_fault = 1; cyc(1); dp_fault = 0;
      chk("R6", "label compare", err_code, 8'h23);
      fifo_empty = 0; do_get();
      sec_miss = 1; cyc(1); sec_miss = 0;
      chk("R6", "sector missing", err_code, 8'h81);
      do_tick();

      // R11 sector count
      sec_count = 16'hFFFD;
      start_op(4'd3, 0);
      do_tick(); do_tick();
      chk("R11", "busy after two of three", op_busy, 1);
      do_tick();
      chk("R11", "done after three", op_busy, 0);
      sec_count = 16'hFFFF;

      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule